// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Clear Unit

This unit gathers the event flags of an I2C controller and turns them into one interrupt line. Ten single-cycle event pulses from the transfer engine each set a sticky flag. Two more flags are level flags that follow the transmit and receive FIFO fill levels against programmable thresholds. A mask register selects which flags may drive the interrupt. Software sees a raw view of all flags and a masked view, and it acknowledges sticky flags by reading clear registers: one clear register per event, and one that clears them all.

A capture register collects the cause bits of a transmit abort. Reading the abort clear register, or the combined clear register, also wipes the capture register. Software must therefore read the cause before it acknowledges the abort. Access uses a simple single-cycle register port. Read data is combinational from the current state, and a read's clearing side effect takes place at the clock edge that ends the access.

Top module: `i2c_irq_status`

## Requirements
- R1: After reset the mask, both thresholds, all sticky flags, the abort capture and `irq` are zero. With both FIFO levels at 0, the raw status therefore reads 0x400.
- R2: A pulse on `evtPulse[i]` sets sticky flag i (raw status bit i), and the flag stays set until it is cleared. The bit order is: 0 RX underflow, 1 RX overflow, 2 TX overflow, 3 read request, 4 TX abort, 5 RX done, 6 activity, 7 stop seen, 8 start seen, 9 general call.
- R3: Register 0x02 is the read/write mask, 12 bits wide. Register 0x01 reads the raw status (register 0x00) ANDed with the mask.
- R4: `irq` is registered. It is 1 in the cycle after any masked status bit is 1, and 0 in the cycle after all masked bits are 0.
- R5: A read of register 0x10+i (i = 0..9) returns sticky flag i in bit 0, with the other bits 0. At the end of that access it clears flag i only.
- R6: A read of register 0x06 returns, in bit 0, the OR of all sticky flags. At the end of that access it clears every sticky flag and the abort capture.
- R7: Raw bit 10 (TX empty) is 1 exactly while `txLevel` is less than or equal to the TX threshold (register 0x03). Clear reads do not affect it.
- R8: Raw bit 11 (RX full) is 1 exactly while `rxLevel` is greater than the RX threshold (register 0x04). A threshold of 0 means one or more entries.
- R9: On a TX abort pulse (bit 4), `abortSrcIn` is ORed into the abort capture, which reads at register 0x05. A read of the TX abort clear register (0x14) zeroes the capture.
- R10: An event pulse in the same cycle as a clear read of its flag wins. The flag ends set, and the abort capture then holds exactly the new `abortSrcIn` value.
- R11: Writes to the status, capture and clear registers change nothing, and reads of non-clear registers change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (triggers clear-on-read) |
| regAddr | input | ADDR_W | Register word address |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for the addressed register |
| evtPulse | input | 10 | Single-cycle event pulses from the transfer engine |
| abortSrcIn | input | ABRT_W | Abort cause bits, captured on a TX abort pulse |
| txLevel | input | LVL_W | Current transmit FIFO fill level |
| rxLevel | input | LVL_W | Current receive FIFO fill level |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the collision between an event and the clear read that targets the same flag. A flag already set, or a fresh pulse one cycle too early, hides the priority. The stimulus therefore first empties the flag with a clear read, then issues a second clear read with the matching pulse in the very same access cycle. It checks both the read value (old flag) and the flag afterwards. The abort capture is driven the same way with a preloaded cause, so the expected capture distinguishes an OR from a replacement. The level flags are swept over every threshold and level pair of the 4-bit configuration.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

  localparam int NUM_EVT  = 10;
  localparam int NUM_FLAG = NUM_EVT + 2;

  localparam int EVT_TX_ABRT   = 4;
  localparam int FLAG_TX_EMPTY = NUM_EVT;
  localparam int FLAG_RX_FULL  = NUM_EVT + 1;

  localparam int ADR_RAW      = 0;
  localparam int ADR_MASKED   = 1;
  localparam int ADR_MASK     = 2;
  localparam int ADR_TX_THR   = 3;
  localparam int ADR_RX_THR   = 4;
  localparam int ADR_ABRT_SRC = 5;
  localparam int ADR_CLR_ALL  = 6;
  localparam int ADR_CLR_BASE = 16;

  typedef struct packed {
    logic [NUM_EVT-1:0] clrEvt;
    logic               clrAll;
    logic               wrMask;
    logic               wrTxThr;
    logic               wrRxThr;
  } strobe_t;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_RAW,
    SEL_MASKED,
    SEL_MASK,
    SEL_TX_THR,
    SEL_RX_THR,
    SEL_ABRT_SRC,
    SEL_CLR_ALL,
    SEL_CLR_EVT
  } rdsel_t;

endpackage

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic               regWe,
  input  logic               regRe,
  input  logic [ADDR_W-1:0]  regAddr,
  output strobe_t            strb,
  output rdsel_t             rdSel,
  output logic [NUM_EVT-1:0] selHit
);

  // one decoder per per-event clear register
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_clrDec
    assign selHit[i] = (regAddr == ADDR_W'(ADR_CLR_BASE + i));
  end

  logic isMask;
  logic isTxThr;
  logic isRxThr;
  logic isClrAll;

  assign isMask   = (regAddr == ADDR_W'(ADR_MASK));
  assign isTxThr  = (regAddr == ADDR_W'(ADR_TX_THR));
  assign isRxThr  = (regAddr == ADDR_W'(ADR_RX_THR));
  assign isClrAll = (regAddr == ADDR_W'(ADR_CLR_ALL));

  always_comb begin
    strb         = '0;
    strb.clrEvt  = regRe ? selHit : '0;
    strb.clrAll  = regRe && isClrAll;
    strb.wrMask  = regWe && isMask;
    strb.wrTxThr = regWe && isTxThr;
    strb.wrRxThr = regWe && isRxThr;
  end

  always_comb begin
    rdSel = SEL_NONE;
    if (|selHit) begin
      rdSel = SEL_CLR_EVT;
    end else begin
      case (regAddr)
        ADDR_W'(ADR_RAW):      rdSel = SEL_RAW;
        ADDR_W'(ADR_MASKED):   rdSel = SEL_MASKED;
        ADDR_W'(ADR_MASK):     rdSel = SEL_MASK;
        ADDR_W'(ADR_TX_THR):   rdSel = SEL_TX_THR;
        ADDR_W'(ADR_RX_THR):   rdSel = SEL_RX_THR;
        ADDR_W'(ADR_ABRT_SRC): rdSel = SEL_ABRT_SRC;
        ADDR_W'(ADR_CLR_ALL):  rdSel = SEL_CLR_ALL;
        default:               rdSel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_irq_datapath.sv
module i2c_irq_datapath
  import i2c_irq_pkg::*;
#(
  parameter int LVL_W  = 4,
  parameter int ABRT_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  rdsel_t              rdSel,
  input  logic [NUM_EVT-1:0]  selHit,
  input  logic [DATA_W-1:0]   regWdata,
  input  logic [NUM_EVT-1:0]  evtPulse,
  input  logic [ABRT_W-1:0]   abortSrcIn,
  input  logic [LVL_W-1:0]    txLevel,
  input  logic [LVL_W-1:0]    rxLevel,
  output logic [NUM_FLAG-1:0] rawStat,
  output logic [NUM_FLAG-1:0] maskedStat,
  output logic [NUM_FLAG-1:0] maskReg,
  output logic [ABRT_W-1:0]   abortSrc,
  output logic [DATA_W-1:0]   regRdata,
  output logic                irq
);

  logic [NUM_EVT-1:0] stickyFlag;
  logic [LVL_W-1:0]   txThr;
  logic [LVL_W-1:0]   rxThr;
  logic               txEmptyLvl;
  logic               rxFullLvl;
  logic               abrtWipe;
  logic               unusedWdata;

  assign unusedWdata = ^regWdata;

  // sticky event flags: a pulse outranks a clear in the same cycle
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_sticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stickyFlag[i] <= 1'b0;
      end else if (evtPulse[i]) begin
        stickyFlag[i] <= 1'b1;
      end else if (strb.clrEvt[i] || strb.clrAll) begin
        stickyFlag[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
      txThr   <= '0;
      rxThr   <= '0;
    end else begin
      if (strb.wrMask)  maskReg <= regWdata[NUM_FLAG-1:0];
      if (strb.wrTxThr) txThr   <= regWdata[LVL_W-1:0];
      if (strb.wrRxThr) rxThr   <= regWdata[LVL_W-1:0];
    end
  end

  // abort cause capture, wiped by the abort clear or the clear-all read
  assign abrtWipe = strb.clrEvt[EVT_TX_ABRT] || strb.clrAll;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      abortSrc <= '0;
    end else if (evtPulse[EVT_TX_ABRT]) begin
      abortSrc <= (abrtWipe ? '0 : abortSrc) | abortSrcIn;
    end else if (abrtWipe) begin
      abortSrc <= '0;
    end
  end

  // level flags follow the FIFO levels directly
  assign txEmptyLvl = (txLevel <= txThr);
  assign rxFullLvl  = (rxLevel > rxThr);

  assign rawStat    = {rxFullLvl, txEmptyLvl, stickyFlag};
  assign maskedStat = rawStat & maskReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else begin
      irq <= |maskedStat;
    end
  end

  always_comb begin
    case (rdSel)
      SEL_RAW:      regRdata = DATA_W'(rawStat);
      SEL_MASKED:   regRdata = DATA_W'(maskedStat);
      SEL_MASK:     regRdata = DATA_W'(maskReg);
      SEL_TX_THR:   regRdata = DATA_W'(txThr);
      SEL_RX_THR:   regRdata = DATA_W'(rxThr);
      SEL_ABRT_SRC: regRdata = DATA_W'(abortSrc);
      SEL_CLR_ALL:  regRdata = DATA_W'(|stickyFlag);
      SEL_CLR_EVT:  regRdata = DATA_W'(|(stickyFlag & selHit));
      default:      regRdata = '0;
    endcase
  end

endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int LVL_W  = 4,
  parameter int ABRT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic               regRe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [NUM_EVT-1:0] evtPulse,
  input  logic [ABRT_W-1:0]  abortSrcIn,
  input  logic [LVL_W-1:0]   txLevel,
  input  logic [LVL_W-1:0]   rxLevel,
  output logic               irq
);

  strobe_t             strb;
  rdsel_t              rdSel;
  logic [NUM_EVT-1:0]  selHit;
  logic [NUM_FLAG-1:0] rawStat;
  logic [NUM_FLAG-1:0] maskedStat;
  logic [NUM_FLAG-1:0] maskReg;
  logic [ABRT_W-1:0]   abortSrc;

  i2c_irq_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .regWe  (regWe),
    .regRe  (regRe),
    .regAddr(regAddr),
    .strb   (strb),
    .rdSel  (rdSel),
    .selHit (selHit)
  );

  i2c_irq_datapath #(
    .LVL_W (LVL_W),
    .ABRT_W(ABRT_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rdSel     (rdSel),
    .selHit    (selHit),
    .regWdata  (regWdata),
    .evtPulse  (evtPulse),
    .abortSrcIn(abortSrcIn),
    .txLevel   (txLevel),
    .rxLevel   (rxLevel),
    .rawStat   (rawStat),
    .maskedStat(maskedStat),
    .maskReg   (maskReg),
    .abortSrc  (abortSrc),
    .regRdata  (regRdata),
    .irq       (irq)
  );

endmodule

// File: rtl/i2c_irq_status_chk.sv
module i2c_irq_status_chk
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int ABRT_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                regRe,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [NUM_EVT-1:0]  evtPulse,
  input logic [NUM_FLAG-1:0] rawStat,
  input logic [NUM_FLAG-1:0] maskReg,
  input logic [ABRT_W-1:0]   abortSrc,
  input logic                irq
);

  logic [NUM_EVT-1:0] clrVec;
  logic               clrAllRd;

  always_comb begin
    clrVec = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (regRe && (regAddr == ADDR_W'(ADR_CLR_BASE + i))) clrVec[i] = 1'b1;
    end
  end

  assign clrAllRd = regRe && (regAddr == ADDR_W'(ADR_CLR_ALL));

  // R4: interrupt line is the masked status one cycle later
  p_irq_follows_r4: assert property (@(posedge clk) disable iff (!rstN)
    irq == $past(|(rawStat & maskReg)));

  // R2 and R10: a pulse always leaves its flag set
  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|evtPulse) |=> ((rawStat[NUM_EVT-1:0] & $past(evtPulse)) == $past(evtPulse)));

  // R2: with no pulse and no read, sticky flags hold
  p_flags_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((evtPulse == '0) && !regRe) |=> $stable(rawStat[NUM_EVT-1:0]));

  // R5: a clear read without a colliding pulse drops the flag
  p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((|clrVec) && ((clrVec & evtPulse) == '0)) |=>
      ((rawStat[NUM_EVT-1:0] & $past(clrVec)) == '0));

  // R6: clear-all empties sticky flags and capture
  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clrAllRd && (evtPulse == '0)) |=> ((rawStat[NUM_EVT-1:0] == '0) && (abortSrc == '0)));

  // R9: abort clear read wipes the capture
  p_abort_wipe_r9: assert property (@(posedge clk) disable iff (!rstN)
    (clrVec[EVT_TX_ABRT] && !evtPulse[EVT_TX_ABRT]) |=> (abortSrc == '0));

endmodule

bind i2c_irq_status i2c_irq_status_chk #(
  .ADDR_W(ADDR_W),
  .ABRT_W(ABRT_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regRe   (regRe),
  .regAddr (regAddr),
  .evtPulse(evtPulse),
  .rawStat (rawStat),
  .maskReg (maskReg),
  .abortSrc(abortSrc),
  .irq     (irq)
);

// File: tb/test_i2c_irq_status.sv
module test_i2c_irq_status;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int LVL_W  = 4;
  localparam int ABRT_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWe = 1'b0;
  logic              regRe = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic [9:0]        evtPulse = '0;
  logic [ABRT_W-1:0] abortSrcIn = '0;
  logic [LVL_W-1:0]  txLevel = '0;
  logic [LVL_W-1:0]  rxLevel = '0;
  logic              irq;

  int  nChk = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  // bench model of the programmer-visible state
  logic [9:0]        latM = '0;
  logic [11:0]       maskM = '0;
  logic [LVL_W-1:0]  txThrM = '0;
  logic [LVL_W-1:0]  rxThrM = '0;
  logic [ABRT_W-1:0] absM = '0;

  always #2 clk = ~clk;

  i2c_irq_status #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W), .ABRT_W(ABRT_W)
  ) i_i2c_irq_status (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .evtPulse(evtPulse),
    .abortSrcIn(abortSrcIn), .txLevel(txLevel), .rxLevel(rxLevel), .irq(irq)
  );

  function automatic logic [15:0] expRaw();
    return {4'b0, (rxLevel > rxThrM), (txLevel <= txThrM), latM};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one access cycle; entered and left just after a falling edge
  task automatic acc(input logic we, input logic re, input int adr,
                     input logic [15:0] wd, input logic [9:0] ev,
                     output logic [15:0] rd);
    logic [9:0] clr;
    regWe = we; regRe = re; regAddr = adr[ADDR_W-1:0]; regWdata = wd; evtPulse = ev;
    #1 rd = regRdata;
    clr = '0;
    if (re && adr >= 16 && adr < 26) clr[adr-16] = 1'b1;
    if (re && adr == 6) clr = '1;
    if (ev[4]) absM = (clr[4] ? '0 : absM) | abortSrcIn;
    else if (clr[4]) absM = '0;
    latM = (latM & ~clr) | ev;
    if (we) begin
      case (adr)
        2: maskM  = wd[11:0];
        3: txThrM = wd[LVL_W-1:0];
        4: rxThrM = wd[LVL_W-1:0];
        default: ;
      endcase
    end
    @(negedge clk);
    regWe = 1'b0; regRe = 1'b0; regWdata = '0; evtPulse = '0;
  endtask

  task automatic rdReg(input int adr, output logic [15:0] rd);
    acc(1'b0, 1'b1, adr, 16'h0, 10'h0, rd);
  endtask

  task automatic wrReg(input int adr, input logic [15:0] wd);
    logic [15:0] dummy;
    acc(1'b1, 1'b0, adr, wd, 10'h0, dummy);
  endtask

  task automatic pulse(input logic [9:0] ev);
    logic [15:0] dummy;
    acc(1'b0, 1'b0, 0, 16'h0, ev, dummy);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    rdReg(0, rd);  chk("R1 raw", rd, 16'h0400);
    rdReg(1, rd);  chk("R1 masked", rd, 16'h0);
    rdReg(2, rd);  chk("R1 mask", rd, 16'h0);
    rdReg(5, rd);  chk("R1 abort capture", rd, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);

    // R2 / R5: every event sets its flag; its clear read clears only it
    txLevel = 4'd15;
    for (int i = 0; i < 10; i++) begin
      int j;
      j = (i + 1) % 10;
      pulse(10'(1 << i) | 10'(1 << j));
      rdReg(0, rd);       chk("R2 set", rd, expRaw());
      rdReg(16 + i, rd);  chk("R5 clear read value", rd, 16'h1);
      rdReg(0, rd);       chk("R5 only own flag cleared", rd, expRaw());
      rdReg(16 + i, rd);  chk("R5 clear read after clear", rd, 16'h0);
      rdReg(16 + j, rd);  chk("R5 neighbour clear", rd, 16'h1);
      rdReg(0, rd);       chk("R5 all clear", rd, 16'h0);
    end

    // R3 / R4: mask sweep with every sticky flag set
    pulse(10'h3FF);
    for (int k = 0; k <= 12; k++) begin
      logic [15:0] m;
      m = (k == 12) ? 16'h0 : 16'(1 << k);
      wrReg(2, m);
      @(negedge clk);
      rdReg(2, rd);  chk("R3 mask readback", rd, {4'b0, maskM});
      rdReg(1, rd);  chk("R3 masked", rd, expRaw() & {4'b0, maskM});
      chk("R4 irq level", {15'b0, irq}, {15'b0, |(expRaw() & {4'b0, maskM})});
    end
    wrReg(2, 16'h0FFF);
    @(negedge clk);
    chk("R4 irq all masked in", {15'b0, irq}, 16'h1);

    // R11: writes to read-only and clear registers change nothing
    for (int a = 0; a < 26; a++) begin
      if (a != 2 && a != 3 && a != 4) wrReg(a, 16'h0000);
    end
    rdReg(0, rd);  chk("R11 raw after stray writes", rd, expRaw());
    rdReg(2, rd);  chk("R11 mask kept", rd, 16'h0FFF);

    // R6: clear-all, and irq falling
    rdReg(6, rd);  chk("R6 clear-all value", rd, 16'h1);
    rdReg(0, rd);  chk("R6 flags cleared", rd, expRaw());
    chk("R6 sticky zero", rd & 16'h03FF, 16'h0);
    rdReg(6, rd);  chk("R6 clear-all empty", rd, 16'h0);
    chk("R4 irq dropped", {15'b0, irq}, 16'h0);
    rxLevel = 4'd3;
    @(negedge clk);
    chk("R4 irq from rx level", {15'b0, irq}, 16'h1);
    rxLevel = 4'd0;
    @(negedge clk);
    chk("R4 irq level gone", {15'b0, irq}, 16'h0);

    // R7: TX empty over every threshold and level
    for (int t = 0; t < 16; t++) begin
      wrReg(3, 16'(t));
      for (int l = 0; l < 16; l++) begin
        txLevel = 4'(l);
        rdReg(0, rd);
        chk("R7 tx empty", {15'b0, rd[10]}, {15'b0, (l <= t)});
      end
    end
    // R7: clear reads leave the level flag alone
    wrReg(3, 16'd5);
    txLevel = 4'd2;
    rdReg(6, rd);
    rdReg(20, rd);
    rdReg(0, rd);  chk("R7 level survives clears", rd, 16'h0400);

    // R8: RX full over every threshold and level
    for (int t = 0; t < 16; t++) begin
      wrReg(4, 16'(t));
      for (int l = 0; l < 16; l++) begin
        rxLevel = 4'(l);
        rdReg(0, rd);
        chk("R8 rx full", {15'b0, rd[11]}, {15'b0, (l > t)});
      end
    end
    wrReg(4, 16'd0);
    rxLevel = 4'd0;
    txLevel = 4'd15;

    // R9: abort capture accumulates and is wiped by its clear
    abortSrcIn = 8'h05;
    pulse(10'h010);
    rdReg(5, rd);   chk("R9 capture", rd, 16'h0005);
    abortSrcIn = 8'h30;
    pulse(10'h010);
    rdReg(5, rd);   chk("R9 capture or", rd, 16'h0035);
    rdReg(0, rd);   chk("R9 raw read keeps capture", rd, expRaw());
    rdReg(5, rd);   chk("R11 capture read keeps capture", rd, 16'h0035);
    rdReg(20, rd);  chk("R9 abort clear value", rd, 16'h1);
    rdReg(5, rd);   chk("R9 capture wiped", rd, 16'h0);
    abortSrcIn = 8'h81;
    pulse(10'h010);
    rdReg(6, rd);
    rdReg(5, rd);   chk("R6 clear-all wipes capture", rd, 16'h0);

    // R10: pulse and clear read in the same cycle
    for (int i = 0; i < 10; i++) begin
      acc(1'b0, 1'b1, 16 + i, 16'h0, 10'(1 << i), rd);
      chk("R10 read value before event", rd, 16'h0);
      rdReg(0, rd);       chk("R10 flag kept", rd, expRaw());
      rdReg(16 + i, rd);  chk("R10 flag then clears", rd, 16'h1);
    end
    abortSrcIn = 8'h0F;
    pulse(10'h010);
    abortSrcIn = 8'h30;
    acc(1'b0, 1'b1, 20, 16'h0, 10'h010, rd);
    chk("R10 abort clear read value", rd, 16'h1);
    rdReg(5, rd);   chk("R10 capture replaced", rd, 16'h0030);
    rdReg(0, rd);   chk("R10 abort flag kept", rd, expRaw());

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule